// File: doc/BRIEF.md
# Two-Channel Capture Event Conditioner

This block is the input side of a two-channel capture timer. It turns two asynchronous input lines into clean capture strobes, one strobe output per channel. Each channel runs a fixed pipeline. First it picks its raw line, then it resynchronises that line in two flops. A majority-free digital filter follows, which only changes its output after a run of identical samples. After the filter come an edge picker with polarity control, a capture-source multiplexer and an event prescaler.

Each channel can trigger on three sources: its own filtered line, the other channel's filtered line, or a synchronous trigger input shared by both channels. When a channel takes the other channel's line, the edge is still judged by this channel's own polarity setting. Channel 1 can also take its raw line from an alternate input in place of its own pin. The strobes feed whatever latches the counter value. That latching, and any interrupt logic, sit outside this block.

Top module: `cap_cond_chain`

## Requirements
- R1: While `rst_ni` is low, `cap_o` is 2'b00, whatever the other inputs do.
- R2: Channel 0's raw line is always `pin_i[0]`. Channel 1's raw line is `alt_i` when `alt_sel_i` is 1 and `pin_i[1]` when it is 0.
- R3: With filter code 0, sample-rate code 0 and divide code 00, a level change on a raw line causes a `cap_o` pulse on the fourth rising clock edge after the change. The pulse lasts exactly one cycle.
- R4: Each channel has a 3-bit filter code in `flen_i` (channel n at bits [3n+2:3n]). Code 0 means the filter changes on a single differing sample. Codes 1 to 4 need 2, 4, 6 or 8 consecutive samples that differ from the current output. Codes 5 to 7 behave like code 4.
- R5: Each channel has a 2-bit sample-rate code r in `frate_i` (channel n at bits [2n+1:2n]). The filter samples once every 2^r clock cycles.
- R6: Each channel has a polarity field in `pol_i` (channel n at bits [2n+1:2n]). Bit 1 set selects both edges. Otherwise bit 0 set selects falling edges, and bit 0 clear selects rising edges.
- R7: Each channel has a 2-bit source field in `src_i` (channel n at bits [2n+1:2n]). 00 selects the channel's own line. 01 selects the other channel's filtered line, judged with this channel's polarity. 10 selects `trig_i`. 11 selects nothing, so the channel makes no pulses.
- R8: `trig_i` is synchronous. Every cycle in which it is high is one event, and that event reaches `cap_o` on the next rising edge.
- R9: Each channel has a 2-bit divide code in `div_i` (channel n at bits [2n+1:2n]). Codes 00, 01, 10 and 11 pass every 1st, 2nd, 4th and 8th selected event. Counting starts after reset or after a restart, so the first pulse comes on the Nth event.
- R10: A change of a channel's divide code restarts that channel's event count. An event that arrives in the same cycle as the change is dropped.
- R11: While `en_i[n]` is low, channel n makes no pulses and its event count restarts.
- R12: Each passed event makes exactly one cycle of `cap_o` high. When the divide code is not 00, a pulse is never followed by a pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | Raw input lines, one per channel |
| alt_i | input | 1 | Alternate raw line for channel 1 |
| alt_sel_i | input | 1 | 1: channel 1 uses `alt_i` |
| trig_i | input | 1 | Synchronous external trigger event |
| en_i | input | 2 | Per-channel enable |
| frate_i | input | 4 | Filter sample-rate codes |
| flen_i | input | 6 | Filter sample-count codes |
| pol_i | input | 4 | Edge polarity fields |
| src_i | input | 4 | Capture source fields |
| div_i | input | 4 | Event divide codes |
| cap_o | output | 2 | Single-cycle capture pulses |

## Verification
The prescaler must settle two things that can land in one cycle: a change of its divide code, which restarts the count, and an arriving event. The bench provokes the clash by moving the code from /2 to /1 in the same cycle that `trig_i` goes high, since the trigger has the shortest path. The expected result is no pulse for that event and a pulse for the next one. A second test leaves three events pending under /4, then switches to /2. The next single event must stay silent, which shows that the stale count was cleared.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  // capture source choice, two bits per channel
  typedef enum logic [1:0] {
    SRC_OWN   = 2'b00,
    SRC_OTHER = 2'b01,
    SRC_TRIG  = 2'b10,
    SRC_NONE  = 2'b11
  } cap_src_e;

  // positions inside a channel's polarity field
  localparam int POL_FALL_BIT = 0;
  localparam int POL_BOTH_BIT = 1;
endpackage

// File: rtl/cc_sync.sv
`timescale 1ns/1ps
module cc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cc_filter.sv
`timescale 1ns/1ps
module cc_filter #(
  parameter int LEN_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             samp_en_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             d_i,
  output logic             q_o
);
  localparam int MAX_CODE = 1 << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             q_q, q_d;

  // lim = differing samples needed minus one
  always_comb begin
    if (len_i == '0)                  lim = '0;
    else if (int'(len_i) >= MAX_CODE) lim = CNT_W'(2 * MAX_CODE - 1);
    else                              lim = CNT_W'(2 * int'(len_i) - 1);
  end

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (samp_en_i) begin
      if (d_i == q_q) begin
        cnt_d = '0;
      end else if (cnt_q >= lim) begin
        q_d   = d_i;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/cc_edge.sv
`timescale 1ns/1ps
module cc_edge (
  input  logic       cur_i,
  input  logic       prv_i,
  input  logic [1:0] pol_i,
  output logic       ev_o
);
  logic rise, fall;

  always_comb begin
    rise = cur_i & ~prv_i;
    fall = ~cur_i & prv_i;
    if (pol_i[cc_pkg::POL_BOTH_BIT])      ev_o = rise | fall;
    else if (pol_i[cc_pkg::POL_FALL_BIT]) ev_o = fall;
    else                                  ev_o = rise;
  end
endmodule

// File: rtl/cc_prescale.sv
`timescale 1ns/1ps
module cc_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ev_i,
  output logic             pulse_o
);
  localparam int CW = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [CW-1:0]    cnt_q, cnt_d, lim;
  logic             pls_q, pls_d, chg;

  always_comb begin
    lim   = CW'((32'd1 << div_i) - 32'd1);
    chg   = (div_i != div_q);
    cnt_d = cnt_q;
    pls_d = 1'b0;
    if (!en_i || chg) begin
      cnt_d = '0;
    end else if (ev_i) begin
      if (cnt_q >= lim) begin
        cnt_d = '0;
        pls_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
      pls_q <= 1'b0;
    end else begin
      div_q <= div_i;
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign pulse_o = pls_q;
endmodule

// File: rtl/cap_cond_chain.sv
`timescale 1ns/1ps
module cap_cond_chain #(
  parameter int SYNC_STAGES = 2,
  parameter int FLEN_W      = 3,
  parameter int FCNT_W      = 3,
  parameter int RATE_W      = 2,
  parameter int DIV_W       = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          pin_i,
  input  logic                alt_i,
  input  logic                alt_sel_i,
  input  logic                trig_i,
  input  logic [1:0]          en_i,
  input  logic [2*RATE_W-1:0] frate_i,
  input  logic [2*FLEN_W-1:0] flen_i,
  input  logic [3:0]          pol_i,
  input  logic [3:0]          src_i,
  input  logic [2*DIV_W-1:0]  div_i,
  output logic [1:0]          cap_o
);
  import cc_pkg::*;

  localparam int NCH  = 2;
  localparam int RC_W = (1 << RATE_W) - 1;

  logic [RC_W-1:0] rc_q, rc_d;
  logic [NCH-1:0]  raw, syn, flt, prv_q, prv_d, samp_en, ev_own, ev_oth;

  // free-running sample-rate counter shared by both filters
  always_comb begin
    rc_d  = rc_q + RC_W'(1);
    prv_d = flt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q  <= '0;
      prv_q <= '0;
    end else begin
      rc_q  <= rc_d;
      prv_q <= prv_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int OTH = NCH - 1 - i;
    logic ev_sel;

    if (i == 1) begin : g_alt
      assign raw[i] = alt_sel_i ? alt_i : pin_i[i];
    end else begin : g_pin
      assign raw[i] = pin_i[i];
    end

    assign samp_en[i] =
      ((rc_q & RC_W'((32'd1 << frate_i[i*RATE_W +: RATE_W]) - 32'd1)) == '0);

    cc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw[i]), .q_o(syn[i])
    );

    cc_filter #(.LEN_W(FLEN_W), .CNT_W(FCNT_W)) u_flt (
      .clk_i(clk_i), .rst_ni(rst_ni), .samp_en_i(samp_en[i]),
      .len_i(flen_i[i*FLEN_W +: FLEN_W]), .d_i(syn[i]), .q_o(flt[i])
    );

    cc_edge u_e_own (
      .cur_i(flt[i]), .prv_i(prv_q[i]), .pol_i(pol_i[2*i +: 2]), .ev_o(ev_own[i])
    );

    cc_edge u_e_oth (
      .cur_i(flt[OTH]), .prv_i(prv_q[OTH]), .pol_i(pol_i[2*i +: 2]), .ev_o(ev_oth[i])
    );

    always_comb begin
      unique case (cap_src_e'(src_i[2*i +: 2]))
        SRC_OWN:   ev_sel = ev_own[i];
        SRC_OTHER: ev_sel = ev_oth[i];
        SRC_TRIG:  ev_sel = trig_i;
        default:   ev_sel = 1'b0;
      endcase
    end

    cc_prescale #(.DIV_W(DIV_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i[i]),
      .div_i(div_i[i*DIV_W +: DIV_W]), .ev_i(ev_sel), .pulse_o(cap_o[i])
    );
  end
endmodule

// File: rtl/cc_chain_chk.sv
`timescale 1ns/1ps
module cc_chain_chk #(
  parameter int DIV_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         en_i,
  input logic [3:0]         src_i,
  input logic [2*DIV_W-1:0] div_i,
  input logic               trig_i,
  input logic [1:0]         cap_o
);
  import cc_pkg::*;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (cap_o == 2'b00);
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_no_back_to_back_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_o[g] && div_i[g*DIV_W +: DIV_W] != '0) |=> !cap_o[g]);

    assert_off_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[g] |=> !cap_o[g]);

    assert_none_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i[2*g +: 2] == SRC_NONE) |=> !cap_o[g]);

    assert_trig_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && en_i[g] && src_i[2*g +: 2] == SRC_TRIG && trig_i &&
       div_i[g*DIV_W +: DIV_W] == '0 && $stable(div_i[g*DIV_W +: DIV_W]))
      |=> cap_o[g]);
  end
endmodule

bind cap_cond_chain cc_chain_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .src_i(src_i),
  .div_i(div_i), .trig_i(trig_i), .cap_o(cap_o)
);

// File: tb/cap_cond_chain_bench.sv
`timescale 1ns/1ps
module cap_cond_chain_bench;
  typedef struct packed {
    logic       alt;
    logic [1:0] pol0, pol1, src0, src1, div0, div1;
    logic [2:0] flen;
    logic [1:0] frate, stim;
    logic [4:0] plen;
    logic [3:0] reps, exp0, exp1, req;
  } vec_t;

  localparam int NV = 20;
  // alt pol0 pol1 src0 src1 div0 div1 flen frate stim plen reps exp0 exp1 req
  localparam vec_t VECS [NV] = '{
    {1'b0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,3'd0,2'd0,2'd0,5'd3,4'd3,4'd3,4'd0,4'd6},  // R6 rising
    {1'b0,2'd1,2'd0,2'd0,2'd0,2'd0,2'd0,3'd0,2'd0,2'd0,5'd3,4'd3,4'd3,4'd0,4'd6},  // R6 falling
    {1'b0,2'd2,2'd0,2'd0,2'd0,2'd0,2'd0,3'd0,2'd0,2'd0,5'd3,4'd3,4'd6,4'd0,4'd6},  // R6 both
    {1'b0,2'd0,2'd2,2'd1,2'd0,2'd0,2'd0,3'd0,2'd0,2'd1,5'd3,4'd3,4'd3,4'd6,4'd7},  // R7 other, own pol
    {1'b0,2'd0,2'd1,2'd0,2'd1,2'd0,2'd0,3'd0,2'd0,2'd0,5'd3,4'd3,4'd3,4'd3,4'd7},  // R7 other falling
    {1'b0,2'd0,2'd0,2'd2,2'd2,2'd0,2'd0,3'd0,2'd0,2'd3,5'd1,4'd5,4'd5,4'd5,4'd8},  // R8 trigger
    {1'b0,2'd0,2'd0,2'd3,2'd0,2'd0,2'd0,3'd0,2'd0,2'd0,5'd3,4'd3,4'd0,4'd0,4'd7},  // R7 none
    {1'b0,2'd0,2'd0,2'd0,2'd1,2'd1,2'd3,3'd0,2'd0,2'd0,5'd3,4'd5,4'd2,4'd0,4'd9},  // R9 /2, /8
    {1'b0,2'd0,2'd0,2'd0,2'd1,2'd2,2'd3,3'd0,2'd0,2'd0,5'd3,4'd8,4'd2,4'd1,4'd9},  // R9 /4, /8
    {1'b0,2'd0,2'd0,2'd0,2'd1,2'd3,2'd0,3'd0,2'd0,2'd0,5'd3,4'd7,4'd0,4'd7,4'd9},  // R9 /8 short
    {1'b1,2'd0,2'd0,2'd1,2'd0,2'd0,2'd0,3'd0,2'd0,2'd1,5'd3,4'd3,4'd0,4'd0,4'd2},  // R2 pin ignored
    {1'b1,2'd0,2'd0,2'd1,2'd0,2'd0,2'd0,3'd0,2'd0,2'd2,5'd3,4'd3,4'd3,4'd3,4'd2},  // R2 alt used
    {1'b0,2'd0,2'd0,2'd1,2'd0,2'd0,2'd0,3'd0,2'd0,2'd2,5'd3,4'd3,4'd0,4'd0,4'd2},  // R2 alt ignored
    {1'b0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,3'd2,2'd0,2'd0,5'd3,4'd3,4'd0,4'd0,4'd4},  // R4 N=4 short
    {1'b0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,3'd2,2'd0,2'd0,5'd4,4'd3,4'd3,4'd0,4'd4},  // R4 N=4 long
    {1'b0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,3'd4,2'd0,2'd0,5'd7,4'd3,4'd0,4'd0,4'd4},  // R4 N=8 short
    {1'b0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,3'd4,2'd0,2'd0,5'd8,4'd3,4'd3,4'd0,4'd4},  // R4 N=8 long
    {1'b0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,3'd6,2'd0,2'd0,5'd7,4'd3,4'd0,4'd0,4'd4},  // R4 clamp
    {1'b0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,3'd2,2'd1,2'd0,5'd6,4'd3,4'd0,4'd0,4'd5},  // R5 slow short
    {1'b0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,3'd2,2'd1,2'd0,5'd10,4'd3,4'd3,4'd0,4'd5}  // R5 slow long
  };

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] pin, en, cap;
  logic       alt, alt_sel, trig;
  logic [3:0] frate, pol, src, div;
  logic [5:0] flen;
  int total = 0, bad = 0, mon0 = 0, mon1 = 0;

  always #4 clk = ~clk;

  cap_cond_chain u_cap_cond_chain (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .alt_i(alt), .alt_sel_i(alt_sel),
    .trig_i(trig), .en_i(en), .frate_i(frate), .flen_i(flen), .pol_i(pol),
    .src_i(src), .div_i(div), .cap_o(cap)
  );

  always @(posedge clk) begin
    if (rst_ni) begin
      mon0 <= mon0 + int'(cap[0]);
      mon1 <= mon1 + int'(cap[1]);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic pulse_stim(logic [1:0] st, int len);
    case (st)
      2'd0: pin[0] = 1'b1;
      2'd1: pin[1] = 1'b1;
      2'd2: alt    = 1'b1;
      default: trig = 1'b1;
    endcase
    step(len);
    pin = 2'b00; alt = 1'b0; trig = 1'b0;
    step(20);
  endtask

  task automatic trig_n(int n);
    repeat (n) begin trig = 1'b1; step(1); trig = 1'b0; step(1); end
  endtask

  initial begin
    #1600000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b0;
    pin = 2'b00; alt = 1'b0; alt_sel = 1'b0; trig = 1'b0; en = 2'b11;
    frate = '0; flen = '0; pol = '0; src = 4'b1010; div = '0;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    // R1: stimulus during reset must not reach the outputs
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      pin = ~pin; trig = 1'b1;
      @(negedge clk);
      chk("R1 reset idle", int'(cap), 0);
    end
    pin = 2'b00; trig = 1'b0; src = 4'b0000;
    @(negedge clk);
    rst_ni = 1'b1;
    step(10);

    // table walk
    for (int k = 0; k < NV; k++) begin
      automatic vec_t v;
      int s0, s1;
      v = VECS[k];
      en = 2'b00;
      alt_sel = v.alt; pol = {v.pol1, v.pol0}; src = {v.src1, v.src0};
      div = {v.div1, v.div0}; flen = {v.flen, v.flen}; frate = {v.frate, v.frate};
      step(30);
      en = 2'b11;
      step(2);
      s0 = mon0; s1 = mon1;
      for (int r = 0; r < int'(v.reps); r++) pulse_stim(v.stim, int'(v.plen));
      step(40);
      chk($sformatf("R%0d vec%0d ch0", v.req, k), mon0 - s0, int'(v.exp0));
      chk($sformatf("R%0d vec%0d ch1", v.req, k), mon1 - s1, int'(v.exp1));
    end

    // R3 / R12: exact latency and width of one pulse
    en = 2'b11; alt_sel = 1'b0; pol = '0; src = '0; div = '0; flen = '0; frate = '0;
    step(30);
    pin[0] = 1'b1;
    step(3); chk("R3 before fourth edge", int'(cap[0]), 0);
    step(1); chk("R3 at fourth edge", int'(cap[0]), 1);
    step(1); chk("R12 one cycle wide", int'(cap[0]), 0);
    pin[0] = 1'b0;
    step(10);

    // R8: trigger path, one cycle, held trigger gives one pulse per cycle
    src = 4'b0010;
    step(2);
    trig = 1'b1;
    step(1); chk("R8 trigger next edge", int'(cap[0]), 1);
    step(1); chk("R8 held trigger c2", int'(cap[0]), 1);
    step(1); chk("R8 held trigger c3", int'(cap[0]), 1);
    trig = 1'b0;
    step(1); chk("R8 trigger released", int'(cap[0]), 0);
    step(3);

    // R10: divide change in the same cycle as an event
    div = 4'b0001;
    step(2);
    trig_n(1);
    div = 4'b0000; trig = 1'b1;
    step(1); chk("R10 coincident event dropped", int'(cap[0]), 0);
    step(1); chk("R10 next event passes", int'(cap[0]), 1);
    trig = 1'b0;
    step(3);

    // R10: stale count cleared by a divide change
    div = 4'b0010;
    step(2);
    b0 = mon0; trig_n(3); chk("R9 /4 three events", mon0 - b0, 0);
    div = 4'b0001;
    step(1);
    b0 = mon0; trig_n(1); chk("R10 restart first event", mon0 - b0, 0);
    trig_n(1); chk("R10 restart second event", mon0 - b0, 1);

    // R11: disable blocks pulses and restarts the count
    div = 4'b0010;
    step(2);
    b0 = mon0; trig_n(3); chk("R11 pending before disable", mon0 - b0, 0);
    en[0] = 1'b0; trig = 1'b1;
    step(1); trig = 1'b0; chk("R11 disabled event", int'(cap[0]), 0);
    en[0] = 1'b1;
    step(1);
    b0 = mon0; trig_n(3); chk("R11 count restarted", mon0 - b0, 0);
    trig_n(1); chk("R11 fourth after restart", mon0 - b0, 1);
    div = 4'b0000;
    en[0] = 1'b0;
    step(2);
    b0 = mon0; trig_n(3); chk("R11 disabled at /1", mon0 - b0, 0);
    en[0] = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule